// File: doc/BRIEF.md
# Digital Clock Rate Corrector

This block trims the divide-by-1024 prescaler of a timekeeping counter so that a slow source clock that runs slightly fast or slightly slow still gives an accurate once-per-second tick. A signed 8-bit trim value says how many single-cycle adjustments to apply in each correction window. The window is 976 blocks of 1024 source cycles, 999424 cycles in all, so one unit of trim is worth about 1.0006 ppm. A positive trim makes the prescaler skip ahead by one extra count. A negative trim makes the prescaler hold its count for one cycle. The adjustments are spread as evenly as an integer schedule allows, and no block gets more than one.

The block owns the window timing, which is a cycle counter and a block counter that run only while the block is enabled. It issues the hold and skip controls to an external prescaler. It also watches the prescaler count and produces the corrected tick each time that count wraps. The trim value is sampled once, at the first cycle of each window. A change made in the middle of a window takes effect only when the next window starts. The prescaler width, the number of blocks per window and the trim limit are parameters. The defaults give the 1 Hz arrangement from a 1024 Hz source.

Top module: `rate_corrector`

## Requirements
- R1: While reset is asserted, presc_stall, presc_extra and tick_1hz are all low.
- R2: The first clock edge with enable high processes cycle 0 of block 0 of a window. A block is 2^PRESC_BITS cycles and a window is WINDOW_BLOCKS blocks. With a trim magnitude m, block b (counted from 0) carries an adjustment exactly when floor((b+1)*m/WINDOW_BLOCKS) > floor(b*m/WINDOW_BLOCKS), so each window carries exactly m adjustments.
- R3: A positive trim drives presc_extra high, meaning advance the prescaler by two, and never drives presc_stall.
- R4: A negative trim drives presc_stall high, meaning hold the prescaler, and never drives presc_extra.
- R5: A trim of zero produces no adjustment.
- R6: The trim magnitude is limited to MAX_STEPS (127). A trim of -128 gives 127 hold adjustments per window.
- R7: corr_value is sampled only on the edge that processes cycle 0 of block 0. A change made later in the window has no effect until the next window.
- R8: With enable low, presc_stall and presc_extra are low from the next edge on. When enable returns high, a fresh window starts as in R2.
- R9: tick_1hz is high in exactly those cycles in which presc_count is below the value it held in the previous cycle.
- R10: An adjustment lasts one cycle and is high only in the cycle that follows cycle 0 of its block. presc_stall and presc_extra are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_slow | input | 1 | Slow source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Runs the correction schedule; low clears it |
| corr_value | input | 8 | Signed trim, adjustments per window |
| presc_count | input | PRESC_BITS | Current count of the external prescaler |
| presc_stall | output | 1 | Hold the prescaler for this cycle |
| presc_extra | output | 1 | Advance the prescaler by two this cycle |
| tick_1hz | output | 1 | Corrected tick, high in the cycle the count wraps |

## Verification
The assertions assume that enable and corr_value change only between clock edges. They also assume that MAX_STEPS is below WINDOW_BLOCKS and that PRESC_BITS is at least 2, so that a one-cycle pulse always falls back low before the next block starts. The bench drives every input at the falling edge. It models the prescaler itself, applying hold or skip from the block's own outputs. It uses a 16-cycle block and a 160-block window, which keeps every trim between -128 and 127 inside those assumptions while whole windows stay short enough to run.

// File: rtl/rcc_pkg.sv
package rcc_pkg;
  localparam int unsigned CORR_W = 8;

  typedef enum logic [1:0] {
    ADJ_NONE = 2'd0,
    ADJ_HOLD = 2'd1,
    ADJ_SKIP = 2'd2
  } adj_e;
endpackage

// File: rtl/rcc_phase_timer.sv
module rcc_phase_timer #(
  parameter int unsigned PRESC_BITS    = 10,
  parameter int unsigned WINDOW_BLOCKS = 976,
  localparam int unsigned BLK_W        = $clog2(WINDOW_BLOCKS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  run,
  output logic [PRESC_BITS-1:0] phase_o,
  output logic [BLK_W-1:0]      block_o,
  output logic                  blk_start_o,
  output logic                  win_start_o
);
  localparam logic [PRESC_BITS-1:0] PH_LAST  = '1;
  localparam logic [BLK_W-1:0]      BLK_LAST = BLK_W'(WINDOW_BLOCKS - 1);

  logic [PRESC_BITS-1:0] phase_q, phase_n;
  logic [BLK_W-1:0]      block_q, block_n;

  always_comb begin
    phase_n = phase_q;
    block_n = block_q;
    if (!run) begin
      phase_n = '0;
      block_n = '0;
    end else begin
      phase_n = phase_q + 1'b1;
      if (phase_q == PH_LAST) begin
        block_n = (block_q == BLK_LAST) ? '0 : block_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      block_q <= '0;
    end else begin
      phase_q <= phase_n;
      block_q <= block_n;
    end
  end

  assign phase_o     = phase_q;
  assign block_o     = block_q;
  assign blk_start_o = run && (phase_q == '0);
  assign win_start_o = blk_start_o && (block_q == '0);
endmodule

// File: rtl/rcc_spreader.sv
module rcc_spreader
  import rcc_pkg::*;
#(
  parameter int unsigned WINDOW_BLOCKS = 976,
  parameter int unsigned MAX_STEPS     = 127,
  localparam int unsigned MAG_W        = $clog2(MAX_STEPS + 1),
  localparam int unsigned ACC_W        = $clog2(WINDOW_BLOCKS + MAX_STEPS + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     run,
  input  logic                     blk_start,
  input  logic                     win_start,
  input  logic signed [CORR_W-1:0] corr_i,
  output adj_e                     adj_o,
  output logic                     neg_o,
  output logic [MAG_W-1:0]         mag_o
);
  localparam logic [ACC_W-1:0] WIN_LIM = ACC_W'(WINDOW_BLOCKS);

  logic [ACC_W-1:0]  acc_q, acc_n;
  logic [MAG_W-1:0]  mag_q, mag_n;
  logic              neg_q, neg_n;
  adj_e              adj_q, adj_n;

  logic [CORR_W-1:0] abs_w;
  logic [MAG_W-1:0]  lim_w;
  logic [MAG_W-1:0]  cur_mag;
  logic              cur_neg;
  logic [ACC_W-1:0]  base_w, sum_w;
  logic              fire_w;

  // Magnitude of the trim, limited to the allowed step count.
  always_comb begin
    abs_w = corr_i[CORR_W-1] ? CORR_W'(-corr_i) : CORR_W'(corr_i);
    if (32'(abs_w) > MAX_STEPS) lim_w = MAG_W'(MAX_STEPS);
    else                        lim_w = abs_w[MAG_W-1:0];
  end

  // Window start takes a fresh trim and a clean accumulator.
  always_comb begin
    cur_mag = win_start ? lim_w : mag_q;
    cur_neg = win_start ? corr_i[CORR_W-1] : neg_q;
    base_w  = win_start ? '0 : acc_q;
    sum_w   = base_w + ACC_W'(cur_mag);
    fire_w  = blk_start && (sum_w >= WIN_LIM);
  end

  always_comb begin
    acc_n = acc_q;
    mag_n = mag_q;
    neg_n = neg_q;
    adj_n = ADJ_NONE;
    if (!run) begin
      acc_n = '0;
      mag_n = '0;
      neg_n = 1'b0;
    end else if (blk_start) begin
      acc_n = fire_w ? (sum_w - WIN_LIM) : sum_w;
      mag_n = cur_mag;
      neg_n = cur_neg;
      if (fire_w) adj_n = cur_neg ? ADJ_HOLD : ADJ_SKIP;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      mag_q <= '0;
      neg_q <= 1'b0;
      adj_q <= ADJ_NONE;
    end else begin
      acc_q <= acc_n;
      mag_q <= mag_n;
      neg_q <= neg_n;
      adj_q <= adj_n;
    end
  end

  assign adj_o = adj_q;
  assign neg_o = neg_q;
  assign mag_o = mag_q;
endmodule

// File: rtl/rcc_wrap_detect.sv
module rcc_wrap_detect #(
  parameter int unsigned PRESC_BITS = 10
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [PRESC_BITS-1:0] count_i,
  output logic                  tick_o
);
  logic [PRESC_BITS-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= count_i;
  end

  // A count below the last sample means the prescaler rolled over.
  assign tick_o = rst_n && (count_i < prev_q);
endmodule

// File: rtl/rate_corrector.sv
module rate_corrector
  import rcc_pkg::*;
#(
  parameter int unsigned PRESC_BITS    = 10,
  parameter int unsigned WINDOW_BLOCKS = 976,
  parameter int unsigned MAX_STEPS     = 127
) (
  input  logic                     clk_slow,
  input  logic                     rst_n,
  input  logic                     enable,
  input  logic signed [CORR_W-1:0] corr_value,
  input  logic [PRESC_BITS-1:0]    presc_count,
  output logic                     presc_stall,
  output logic                     presc_extra,
  output logic                     tick_1hz
);
  localparam int unsigned BLK_W = $clog2(WINDOW_BLOCKS);
  localparam int unsigned MAG_W = $clog2(MAX_STEPS + 1);

  logic [PRESC_BITS-1:0] phase_w;
  logic [BLK_W-1:0]      block_w;
  logic                  blk_start_w, win_start_w;
  adj_e                  adj_w;
  logic                  neg_w;
  logic [MAG_W-1:0]      mag_w;

  rcc_phase_timer #(
    .PRESC_BITS   (PRESC_BITS),
    .WINDOW_BLOCKS(WINDOW_BLOCKS)
  ) timer_i (
    .clk        (clk_slow),
    .rst_n      (rst_n),
    .run        (enable),
    .phase_o    (phase_w),
    .block_o    (block_w),
    .blk_start_o(blk_start_w),
    .win_start_o(win_start_w)
  );

  rcc_spreader #(
    .WINDOW_BLOCKS(WINDOW_BLOCKS),
    .MAX_STEPS    (MAX_STEPS)
  ) spread_i (
    .clk      (clk_slow),
    .rst_n    (rst_n),
    .run      (enable),
    .blk_start(blk_start_w),
    .win_start(win_start_w),
    .corr_i   (corr_value),
    .adj_o    (adj_w),
    .neg_o    (neg_w),
    .mag_o    (mag_w)
  );

  rcc_wrap_detect #(
    .PRESC_BITS(PRESC_BITS)
  ) wrap_i (
    .clk    (clk_slow),
    .rst_n  (rst_n),
    .count_i(presc_count),
    .tick_o (tick_1hz)
  );

  assign presc_stall = (adj_w == ADJ_HOLD);
  assign presc_extra = (adj_w == ADJ_SKIP);
endmodule

// File: rtl/rate_corrector_chk.sv
module rate_corrector_chk #(
  parameter int unsigned PRESC_BITS    = 10,
  parameter int unsigned WINDOW_BLOCKS = 976,
  parameter int unsigned MAX_STEPS     = 127
) (
  input logic                                 clk,
  input logic                                 rst_n,
  input logic                                 enable,
  input logic                                 stall,
  input logic                                 extra,
  input logic [PRESC_BITS-1:0]                phase,
  input logic [$clog2(WINDOW_BLOCKS)-1:0]     block,
  input logic                                 neg,
  input logic [$clog2(MAX_STEPS+1)-1:0]       mag
);
  a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(stall && extra));

  a_r10_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (stall || extra) |=> !(stall || extra));

  a_r10_phase_one: assert property (@(posedge clk) disable iff (!rst_n)
    (stall || extra) |-> (phase == PRESC_BITS'(1)));

  a_r3_extra_positive: assert property (@(posedge clk) disable iff (!rst_n)
    extra |-> !neg);

  a_r4_stall_negative: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> neg);

  a_r6_mag_limit: assert property (@(posedge clk) disable iff (!rst_n)
    32'(mag) <= MAX_STEPS);

  a_r7_trim_held: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !(phase == '0 && block == '0)) |=> $stable(mag));

  a_r8_quiet_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !(stall || extra));
endmodule

bind rate_corrector rate_corrector_chk #(
  .PRESC_BITS   (PRESC_BITS),
  .WINDOW_BLOCKS(WINDOW_BLOCKS),
  .MAX_STEPS    (MAX_STEPS)
) chk_i (
  .clk   (clk_slow),
  .rst_n (rst_n),
  .enable(enable),
  .stall (presc_stall),
  .extra (presc_extra),
  .phase (phase_w),
  .block (block_w),
  .neg   (neg_w),
  .mag   (mag_w)
);

// File: tb/rate_corrector_tb_top.sv
module rate_corrector_tb_top;
  localparam int PB  = 4;
  localparam int NB  = 160;
  localparam int MS  = 127;
  localparam int S   = 1 << PB;
  localparam int WIN = S * NB;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              enable;
  logic signed [7:0] corr_value;
  logic [PB-1:0]     presc_count;
  logic              presc_stall, presc_extra, tick_1hz;

  int n_checks = 0;
  int n_fail   = 0;
  int pm       = 0;

  always #5 clk = ~clk;

  rate_corrector #(
    .PRESC_BITS(PB), .WINDOW_BLOCKS(NB), .MAX_STEPS(MS)
  ) dut_i (
    .clk_slow(clk), .rst_n(rst_n), .enable(enable), .corr_value(corr_value),
    .presc_count(presc_count), .presc_stall(presc_stall),
    .presc_extra(presc_extra), .tick_1hz(tick_1hz)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit fire_at(input int b, input int m);
    return ((b + 1) * m) / NB > (b * m) / NB;
  endfunction

  function automatic int mag_of(input int v);
    int a;
    a = (v < 0) ? -v : v;
    return (a > MS) ? MS : a;
  endfunction

  // Runs len cycles from window position t0, checking adjustments and tick.
  task automatic run_span(input string req, input int t0, input int len,
                          input int m, input bit neg, input bit on,
                          output int cnt);
    int bad = 0, tbad = 0, fa = 0, fe = 0, ta = 0, te = 0;
    cnt = 0;
    for (int k = 0; k < len; k++) begin
      int t, nxt;
      bit ea, es, ex, et;
      t = (t0 + k) % WIN;
      @(posedge clk);
      @(negedge clk);
      ea = on && (t % S == 0) && fire_at(t / S, m);
      es = ea && neg;
      ex = ea && !neg;
      if (presc_stall !== es || presc_extra !== ex) begin
        if (bad == 0) begin
          fa = {30'd0, presc_stall, presc_extra};
          fe = {30'd0, es, ex};
        end
        bad++;
      end
      if (presc_stall || presc_extra) cnt++;
      nxt = presc_stall ? pm : (presc_extra ? pm + 2 : pm + 1);
      nxt = nxt % S;
      presc_count = PB'(nxt);
      #1;
      et = (nxt < pm);
      if (tick_1hz !== et) begin
        if (tbad == 0) begin
          ta = int'(tick_1hz);
          te = int'(et);
        end
        tbad++;
      end
      pm = nxt;
    end
    check(bad == 0, req, "adjust pattern {stall,extra}", fa, fe);
    check(tbad == 0, "R9", "tick on wrap", ta, te);
  endtask

  task automatic restart(input int v);
    int c;
    @(negedge clk);
    enable = 1'b0;
    run_span("R8", 0, 3, 0, 1'b0, 1'b0, c);
    enable     = 1'b1;
    corr_value = 8'(v);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; enable = 1'b0; corr_value = 8'sd0; presc_count = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(presc_stall === 1'b0, "R1", "stall in reset", int'(presc_stall), 0);
    check(presc_extra === 1'b0, "R1", "extra in reset", int'(presc_extra), 0);
    check(tick_1hz === 1'b0, "R1", "tick in reset", int'(tick_1hz), 0);
    rst_n = 1'b1;
  endtask

  task automatic t_window(input string req, input int v);
    int c;
    restart(v);
    run_span(req, 0, WIN, mag_of(v), v < 0, 1'b1, c);
    check(c == mag_of(v), "R2", {req, " adjustments per window"}, c, mag_of(v));
  endtask

  task automatic t_late_change;
    int c1, c2, c3;
    restart(3);
    run_span("R7", 0, 3 * S, 3, 1'b0, 1'b1, c1);
    corr_value = -8'sd9;
    run_span("R7", 3 * S, WIN - 3 * S, 3, 1'b0, 1'b1, c2);
    check(c1 + c2 == 3, "R7", "old trim kept to window end", c1 + c2, 3);
    run_span("R7", 0, WIN, 9, 1'b1, 1'b1, c3);
    check(c3 == 9, "R7", "new trim in next window", c3, 9);
  endtask

  task automatic t_enable_drop;
    int c;
    restart(20);
    run_span("R8", 0, 5 * S + 4, 20, 1'b0, 1'b1, c);
    enable = 1'b0;
    run_span("R8", 0, 40, 20, 1'b0, 1'b0, c);
    check(c == 0, "R8", "adjustments while disabled", c, 0);
    enable = 1'b1;
    run_span("R8", 0, WIN, 20, 1'b0, 1'b1, c);
    check(c == 20, "R8", "fresh window after enable", c, 20);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_window("R3", 5);
    t_window("R4", -7);
    t_window("R5", 0);
    t_window("R3", 127);
    t_window("R6", -128);
    t_late_change();
    t_enable_drop();
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule